// File: doc/BRIEF.md
# Privilege-Banked Register File

This block holds the programmer-visible registers of a 32-bit processor core. It has sixteen general registers, eight for data and eight for addresses. Two registered read ports and one write port reach them, and the write port takes byte, word or long-word sizes. The last address register has no storage of its own. It points to one of two physical stack pointers, and the current privilege level decides which one: the user stack pointer or the supervisor stack pointer.

A second port reaches four control registers: the status register, the vector base, and two 3-bit alternate function codes. This port checks privilege. User-mode code can only reach the condition-code byte of the status register. Any other attempt from user mode is blocked and raises a one-cycle violation flag. A separate path adds the vector base to a vector displacement and returns the address of an exception vector.

Top module: `banked_regfile`

## Requirements
- R1: A synchronous active-high reset leaves the block in supervisor mode. The status register becomes 0x2700 (interrupt mask 7). The vector base and both function codes become 0. `priv_viol`, `cr_rdata`, `vec_addr` and both read ports become 0. Reset does not clear the general registers or the stack pointers.
- R2: Register index 0–7 selects D0–D7 and 8–15 selects A0–A7. Each read port returns the selected register one clock after the index is presented. The two ports are independent.
- R3: `wr_size` is coded 0 = byte, 1 = word, 2 = long, and code 3 writes nothing. On a data register, a byte write replaces bits 7:0 and a word write replaces bits 15:0. All other bits keep their value.
- R4: On an address register, a word write sign-extends bit 15 into all 32 bits and a long write stores all 32 bits. A byte write leaves the register unchanged.
- R5: Index 15 reaches the user stack pointer while the supervisor bit is 0 and the supervisor stack pointer while it is 1. The two hold separate values.
- R6: A read and a write of the same register in the same cycle return the value held before that write. The next read returns the new value.
- R7: `cr_sel` is coded 0 = status, 1 = vector base, 2 = source function code, 3 = destination function code. In the status register, bit 13 is the supervisor bit and bits 10:8 are the interrupt mask (`int_mask`). In supervisor mode, a status write with `cr_hi` = 1 stores all 16 bits, and a write with `cr_hi` = 0 stores only bits 7:0.
- R8: In user mode, a status read returns bits 7:0 and zero above them. A status write with `cr_hi` = 0 updates bits 7:0 and raises no violation.
- R9: In user mode, any access to selector 1, 2 or 3, and any status write with `cr_hi` = 1, changes no state. A read of this kind returns 0. Each such access sets `priv_viol` for exactly the one cycle after it.
- R10: A status write that clears bit 13 changes the index-15 mapping starting with the next cycle's access. An access in the same cycle as that write still uses the old mapping.
- R11: `vec_addr` equals the vector base plus `vec_num` × 4, one clock after `vec_num` is presented. It uses the vector base value held before any write at that same edge.
- R12: The function-code registers are 3 bits wide. A write keeps `cr_wdata[2:0]`, and a read returns the value zero-extended to 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_a_idx | input | 4 | Read port A register index |
| rd_b_idx | input | 4 | Read port B register index |
| rd_a_data | output | 32 | Read port A data, registered |
| rd_b_data | output | 32 | Read port B data, registered |
| wr_en | input | 1 | General register write enable |
| wr_idx | input | 4 | Write register index |
| wr_size | input | 2 | Write size code |
| wr_data | input | 32 | Write data |
| cr_en | input | 1 | Control register access strobe |
| cr_we | input | 1 | Control access is a write |
| cr_sel | input | 2 | Control register selector |
| cr_hi | input | 1 | Status write includes the upper byte |
| cr_wdata | input | 32 | Control write data |
| cr_rdata | output | 32 | Control read data, registered |
| priv_viol | output | 1 | One-cycle privilege violation flag |
| sup_mode | output | 1 | Current supervisor bit |
| int_mask | output | 3 | Current interrupt priority mask |
| vec_num | input | 8 | Exception vector number |
| vec_addr | output | 32 | Exception vector address, registered |

## Verification
Two same-cycle collisions are the risky ones. The first is a status write that leaves supervisor mode while a general-register access to index 15 happens in the same clock. The bench drives both on one edge. It then checks that the same-cycle write went to the supervisor stack pointer and that the same-cycle read returned the supervisor value. Only later accesses should reach the user pointer, and the bench confirms this by reading both pointers back after a reset and after a fresh mode change. The second collision is a vector-base write presented together with a vector lookup. The bench expects the old base in that cycle and the new base in the next.

// File: rtl/rf_pkg.sv
package rf_pkg;

  localparam int unsigned DATA_W  = 32;
  localparam int unsigned N_DREG  = 8;
  localparam int unsigned N_AREG  = 8;
  localparam int unsigned N_GREG  = N_DREG + N_AREG;
  localparam int unsigned IDX_W   = $clog2(N_GREG);
  localparam int unsigned SR_W    = 16;
  localparam int unsigned FC_W    = 3;
  localparam int unsigned SR_SUP_BIT = 13;
  localparam int unsigned SR_MASK_LO = 8;
  localparam logic [SR_W-1:0] SR_RESET = 16'h2700;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_NONE = 2'd3
  } wsize_e;

  typedef enum logic [1:0] {
    CSEL_SR  = 2'd0,
    CSEL_VBR = 2'd1,
    CSEL_SFC = 2'd2,
    CSEL_DFC = 2'd3
  } csel_e;

endpackage

// File: rtl/rf_write_fmt.sv
module rf_write_fmt
  import rf_pkg::*;
#(
  parameter int unsigned DW     = DATA_W,
  parameter int unsigned NDREG  = N_DREG,
  parameter int unsigned IW     = IDX_W,
  localparam int unsigned LANES = DW / 8
) (
  input  logic [IW-1:0]    idx,
  input  logic [1:0]       size,
  input  logic [DW-1:0]    din,
  output logic [LANES-1:0] lane_en,
  output logic [DW-1:0]    dout
);

  logic is_addr;
  assign is_addr = (32'(idx) >= NDREG);

  always_comb begin
    lane_en = '0;
    dout    = din;
    unique case (wsize_e'(size))
      SZ_BYTE: begin
        if (!is_addr) lane_en[0] = 1'b1;
      end
      SZ_WORD: begin
        if (is_addr) begin
          lane_en = '1;
          dout    = {{(DW-16){din[15]}}, din[15:0]};
        end else begin
          lane_en[1:0] = 2'b11;
        end
      end
      SZ_LONG: lane_en = '1;
      default: lane_en = '0;
    endcase
  end

endmodule

// File: rtl/rf_gpr_bank.sv
module rf_gpr_bank
  import rf_pkg::*;
#(
  parameter int unsigned DW     = DATA_W,
  parameter int unsigned NGREG  = N_GREG,
  parameter int unsigned IW     = IDX_W,
  localparam int unsigned LANES = DW / 8,
  localparam int unsigned NPHYS = NGREG + 1,
  localparam int unsigned PW    = $clog2(NPHYS),
  localparam int unsigned SP_IDX = NGREG - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sup,
  input  logic [IW-1:0]    rd_a_idx,
  input  logic [IW-1:0]    rd_b_idx,
  input  logic             wr_en,
  input  logic [IW-1:0]    wr_idx,
  input  logic [LANES-1:0] wr_lane,
  input  logic [DW-1:0]    wr_word,
  output logic [DW-1:0]    rd_a_data,
  output logic [DW-1:0]    rd_b_data
);

  function automatic logic [PW-1:0] to_phys(input logic [IW-1:0] i, input logic s);
    if (32'(i) == SP_IDX && s) return PW'(NPHYS - 1);
    return PW'(i);
  endfunction

  logic [PW-1:0] pa, pb, pw;
  assign pa = to_phys(rd_a_idx, sup);
  assign pb = to_phys(rd_b_idx, sup);
  assign pw = to_phys(wr_idx, sup);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] mem [NPHYS];
    logic [7:0] qa, qb;

    always_ff @(posedge clk) begin
      if (wr_en && wr_lane[l]) mem[pw] <= wr_word[8*l +: 8];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        qa <= '0;
        qb <= '0;
      end else begin
        qa <= mem[pa];
        qb <= mem[pb];
      end
    end

    assign rd_a_data[8*l +: 8] = qa;
    assign rd_b_data[8*l +: 8] = qb;
  end

endmodule

// File: rtl/rf_ctrl_regs.sv
module rf_ctrl_regs
  import rf_pkg::*;
#(
  parameter int unsigned DW  = DATA_W,
  parameter int unsigned SRW = SR_W,
  parameter int unsigned FCW = FC_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cr_en,
  input  logic          cr_we,
  input  logic [1:0]    cr_sel,
  input  logic          cr_hi,
  input  logic [DW-1:0] cr_wdata,
  output logic [DW-1:0] cr_rdata,
  output logic          priv_viol,
  output logic          sup,
  output logic [2:0]    imask,
  output logic [DW-1:0] vbr_q
);

  logic [SRW-1:0] sr_q;
  logic [FCW-1:0] sfc_q, dfc_q;
  logic           denied;
  logic [DW-1:0]  rd_val;
  csel_e          sel;

  assign sel   = csel_e'(cr_sel);
  assign sup   = sr_q[SR_SUP_BIT];
  assign imask = sr_q[SR_MASK_LO +: 3];

  assign denied = !sup && ((sel != CSEL_SR) || (cr_we && cr_hi));

  always_comb begin
    unique case (sel)
      CSEL_SR:  rd_val = sup ? DW'(sr_q) : DW'(sr_q[7:0]);
      CSEL_VBR: rd_val = vbr_q;
      CSEL_SFC: rd_val = DW'(sfc_q);
      default:  rd_val = DW'(dfc_q);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q      <= SR_RESET;
      vbr_q     <= '0;
      sfc_q     <= '0;
      dfc_q     <= '0;
      cr_rdata  <= '0;
      priv_viol <= 1'b0;
    end else begin
      priv_viol <= cr_en && denied;
      if (cr_en && cr_we && !denied) begin
        unique case (sel)
          CSEL_SR: begin
            sr_q[7:0] <= cr_wdata[7:0];
            if (cr_hi) sr_q[SRW-1:8] <= cr_wdata[SRW-1:8];
          end
          CSEL_VBR: vbr_q <= cr_wdata;
          CSEL_SFC: sfc_q <= cr_wdata[FCW-1:0];
          default:  dfc_q <= cr_wdata[FCW-1:0];
        endcase
      end
      if (cr_en && !cr_we) cr_rdata <= denied ? '0 : rd_val;
    end
  end

endmodule

// File: rtl/rf_vector_gen.sv
module rf_vector_gen #(
  parameter int unsigned DW = 32,
  parameter int unsigned VW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] base,
  input  logic [VW-1:0] vnum,
  output logic [DW-1:0] vaddr
);

  logic [DW-1:0] disp;
  assign disp = DW'({vnum, 2'b00});

  always_ff @(posedge clk) begin
    if (rst) vaddr <= '0;
    else     vaddr <= base + disp;
  end

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import rf_pkg::*;
#(
  parameter int unsigned DW    = DATA_W,
  parameter int unsigned NDREG = N_DREG,
  parameter int unsigned NAREG = N_AREG,
  parameter int unsigned VW    = 8,
  localparam int unsigned NG    = NDREG + NAREG,
  localparam int unsigned IW    = $clog2(NG),
  localparam int unsigned LANES = DW / 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] rd_a_idx,
  input  logic [IW-1:0] rd_b_idx,
  output logic [DW-1:0] rd_a_data,
  output logic [DW-1:0] rd_b_data,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [1:0]    wr_size,
  input  logic [DW-1:0] wr_data,
  input  logic          cr_en,
  input  logic          cr_we,
  input  logic [1:0]    cr_sel,
  input  logic          cr_hi,
  input  logic [DW-1:0] cr_wdata,
  output logic [DW-1:0] cr_rdata,
  output logic          priv_viol,
  output logic          sup_mode,
  output logic [2:0]    int_mask,
  input  logic [VW-1:0] vec_num,
  output logic [DW-1:0] vec_addr
);

  logic [LANES-1:0] lane_en;
  logic [DW-1:0]    wword;
  logic [DW-1:0]    vbr;

  rf_write_fmt #(.DW(DW), .NDREG(NDREG), .IW(IW)) u_fmt (
    .idx(wr_idx), .size(wr_size), .din(wr_data),
    .lane_en(lane_en), .dout(wword)
  );

  rf_gpr_bank #(.DW(DW), .NGREG(NG), .IW(IW)) u_bank (
    .clk(clk), .rst(rst), .sup(sup_mode),
    .rd_a_idx(rd_a_idx), .rd_b_idx(rd_b_idx),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_lane(lane_en), .wr_word(wword),
    .rd_a_data(rd_a_data), .rd_b_data(rd_b_data)
  );

  rf_ctrl_regs #(.DW(DW)) u_ctrl (
    .clk(clk), .rst(rst), .cr_en(cr_en), .cr_we(cr_we), .cr_sel(cr_sel),
    .cr_hi(cr_hi), .cr_wdata(cr_wdata), .cr_rdata(cr_rdata),
    .priv_viol(priv_viol), .sup(sup_mode), .imask(int_mask), .vbr_q(vbr)
  );

  rf_vector_gen #(.DW(DW), .VW(VW)) u_vec (
    .clk(clk), .rst(rst), .base(vbr), .vnum(vec_num), .vaddr(vec_addr)
  );

endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk #(
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          cr_en,
  input logic          cr_we,
  input logic [1:0]    cr_sel,
  input logic [DW-1:0] cr_rdata,
  input logic          priv_viol,
  input logic          sup_mode,
  input logic [2:0]    int_mask
);

  logic prev_rst = 1'b0;
  logic seen_rst = 1'b0;
  logic live     = 1'b0;

  always_ff @(posedge clk) begin
    prev_rst <= rst;
    seen_rst <= seen_rst | rst;
    live     <= rst ? 1'b0 : seen_rst;
  end

  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    prev_rst |-> (sup_mode && int_mask == 3'd7 && !priv_viol && cr_rdata == '0));

  a_r9_viol_cause: assert property (@(posedge clk) disable iff (rst)
    (live && priv_viol) |-> ($past(cr_en) && !$past(sup_mode)));

  a_r9_denied_read_zero: assert property (@(posedge clk) disable iff (rst)
    (live && $past(cr_en && !cr_we && cr_sel != 2'd0 && !sup_mode)) |-> (cr_rdata == '0));

  a_r8_user_sr_low: assert property (@(posedge clk) disable iff (rst)
    (live && $past(cr_en && !cr_we && cr_sel == 2'd0 && !sup_mode)) |-> (cr_rdata[DW-1:8] == '0));

  a_r10_user_sticky: assert property (@(posedge clk) disable iff (rst)
    (live && !sup_mode) |=> !sup_mode);

  a_r12_fc_width: assert property (@(posedge clk) disable iff (rst)
    (live && $past(cr_en && !cr_we && cr_sel[1])) |-> (cr_rdata[DW-1:3] == '0));

endmodule

bind banked_regfile banked_regfile_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .cr_en(cr_en), .cr_we(cr_we), .cr_sel(cr_sel),
  .cr_rdata(cr_rdata), .priv_viol(priv_viol), .sup_mode(sup_mode),
  .int_mask(int_mask)
);

// File: tb/banked_regfile_test.sv
module banked_regfile_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = '0, cr_wdata = '0, cr_rdata, vec_addr;
  logic        wr_en = 1'b0, cr_en = 1'b0, cr_we = 1'b0, cr_hi = 1'b0;
  logic [1:0]  wr_size = '0, cr_sel = '0;
  logic        priv_viol, sup_mode;
  logic [2:0]  int_mask;
  logic [7:0]  vec_num = '0;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  banked_regfile uut (
    .clk(clk), .rst(rst), .rd_a_idx(rd_a_idx), .rd_b_idx(rd_b_idx),
    .rd_a_data(rd_a_data), .rd_b_data(rd_b_data), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_size(wr_size), .wr_data(wr_data), .cr_en(cr_en), .cr_we(cr_we),
    .cr_sel(cr_sel), .cr_hi(cr_hi), .cr_wdata(cr_wdata), .cr_rdata(cr_rdata),
    .priv_viol(priv_viol), .sup_mode(sup_mode), .int_mask(int_mask),
    .vec_num(vec_num), .vec_addr(vec_addr)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; wr_en = 0; cr_en = 0;
    tick(); tick();
    rst = 1'b0;
  endtask

  task automatic gw(input logic [3:0] idx, input logic [1:0] sz, input logic [31:0] d);
    wr_en = 1; wr_idx = idx; wr_size = sz; wr_data = d;
    tick();
    wr_en = 0;
  endtask

  task automatic gr(input logic [3:0] idx, output logic [31:0] v);
    rd_a_idx = idx;
    tick();
    v = rd_a_data;
  endtask

  task automatic crw(input logic [1:0] sel, input logic hi, input logic [31:0] d, output logic viol);
    cr_en = 1; cr_we = 1; cr_sel = sel; cr_hi = hi; cr_wdata = d;
    tick();
    viol = priv_viol;
    cr_en = 0; cr_we = 0;
  endtask

  task automatic crr(input logic [1:0] sel, output logic [31:0] v, output logic viol);
    cr_en = 1; cr_we = 0; cr_sel = sel; cr_hi = 0;
    tick();
    v = rd_a_data; v = cr_rdata;
    viol = priv_viol;
    cr_en = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v; logic vl;
    do_reset();
    chk("R1", "sup_mode", 32'(sup_mode), 32'd1);
    chk("R1", "int_mask", 32'(int_mask), 32'd7);
    chk("R1", "priv_viol", 32'(priv_viol), 32'd0);
    chk("R1", "vec_addr", vec_addr, 32'd0);
    crr(2'd0, v, vl); chk("R1", "SR", v, 32'h2700);
    crr(2'd1, v, vl); chk("R1", "VBR", v, 32'h0);
    crr(2'd3, v, vl); chk("R1", "DFC", v, 32'h0);
  endtask

  task automatic t_data_sizes();
    logic [31:0] v;
    do_reset();
    gw(4'd3, 2'd2, 32'h11223344);
    gw(4'd0, 2'd2, 32'hA0A0A0A0);
    gw(4'd7, 2'd2, 32'h07070707);
    gr(4'd3, v); chk("R3", "D3 long", v, 32'h11223344);
    gw(4'd3, 2'd0, 32'hFFFFFFAA);
    gr(4'd3, v); chk("R3", "D3 byte", v, 32'h112233AA);
    gw(4'd3, 2'd1, 32'hFFFFBEEF);
    gr(4'd3, v); chk("R3", "D3 word", v, 32'h1122BEEF);
    gw(4'd3, 2'd3, 32'h0);
    gr(4'd3, v); chk("R3", "D3 size code 3", v, 32'h1122BEEF);
    rd_a_idx = 4'd0; rd_b_idx = 4'd7;
    tick();
    chk("R2", "port A D0", rd_a_data, 32'hA0A0A0A0);
    chk("R2", "port B D7", rd_b_data, 32'h07070707);
  endtask

  task automatic t_addr();
    logic [31:0] v;
    do_reset();
    gw(4'd10, 2'd1, 32'h00008001);
    gr(4'd10, v); chk("R4", "A2 word neg", v, 32'hFFFF8001);
    gw(4'd10, 2'd1, 32'hABCD7FFF);
    gr(4'd10, v); chk("R4", "A2 word pos", v, 32'h00007FFF);
    gw(4'd10, 2'd2, 32'hDEADBEEF);
    gr(4'd10, v); chk("R4", "A2 long", v, 32'hDEADBEEF);
    gw(4'd10, 2'd0, 32'h00000055);
    gr(4'd10, v); chk("R4", "A2 byte ignored", v, 32'hDEADBEEF);
  endtask

  task automatic t_same_cycle();
    logic [31:0] v;
    do_reset();
    gw(4'd5, 2'd2, 32'h1);
    wr_en = 1; wr_idx = 4'd5; wr_size = 2'd2; wr_data = 32'h2; rd_a_idx = 4'd5;
    tick();
    wr_en = 0;
    chk("R6", "same-cycle read old", rd_a_data, 32'h1);
    gr(4'd5, v); chk("R6", "next read new", v, 32'h2);
  endtask

  task automatic t_bank();
    logic [31:0] v; logic vl;
    do_reset();
    gw(4'd15, 2'd2, 32'h00005000);
    gw(4'd14, 2'd2, 32'h0000A6A6);
    gr(4'd15, v); chk("R5", "SSP in supervisor", v, 32'h00005000);
    // mode switch and A7 write plus A7 read in the same cycle
    cr_en = 1; cr_we = 1; cr_sel = 2'd0; cr_hi = 1; cr_wdata = 32'h0;
    wr_en = 1; wr_idx = 4'd15; wr_size = 2'd2; wr_data = 32'h00007777; rd_a_idx = 4'd15;
    tick();
    cr_en = 0; cr_we = 0; wr_en = 0;
    chk("R10", "same-cycle A7 read uses old mapping", rd_a_data, 32'h00005000);
    chk("R10", "sup_mode cleared", 32'(sup_mode), 32'd0);
    gw(4'd15, 2'd2, 32'h00001000);
    gr(4'd15, v); chk("R5", "USP in user", v, 32'h00001000);
    do_reset();
    gr(4'd15, v); chk("R10", "same-cycle A7 write went to SSP", v, 32'h00007777);
    gr(4'd14, v); chk("R5", "A6 unaffected", v, 32'h0000A6A6);
    crw(2'd0, 1'b1, 32'h00000500, vl);
    chk("R7", "int_mask after user SR", 32'(int_mask), 32'd5);
    gr(4'd15, v); chk("R5", "USP kept", v, 32'h00001000);
  endtask

  task automatic t_sr_super();
    logic [31:0] v; logic vl;
    do_reset();
    crw(2'd0, 1'b0, 32'h0000FF1F, vl);
    chk("R7", "low-byte write no viol", 32'(vl), 32'd0);
    crr(2'd0, v, vl); chk("R7", "SR low only", v, 32'h0000271F);
    crw(2'd0, 1'b1, 32'h00002512, vl);
    crr(2'd0, v, vl); chk("R7", "SR full", v, 32'h00002512);
    chk("R7", "int_mask", 32'(int_mask), 32'd5);
  endtask

  task automatic t_user();
    logic [31:0] v; logic vl;
    do_reset();
    crw(2'd1, 1'b0, 32'h00002000, vl);
    crw(2'd2, 1'b0, 32'h00000005, vl);
    crw(2'd0, 1'b1, 32'h00000003, vl);
    chk("R9", "no viol in supervisor", 32'(vl), 32'd0);
    crr(2'd0, v, vl); chk("R8", "user SR read", v, 32'h00000003);
    chk("R8", "user SR read no viol", 32'(vl), 32'd0);
    crw(2'd0, 1'b0, 32'h00000011, vl);
    chk("R8", "user CCR write no viol", 32'(vl), 32'd0);
    crr(2'd0, v, vl); chk("R8", "user CCR updated", v, 32'h00000011);
    crw(2'd0, 1'b1, 32'h00002700, vl);
    chk("R9", "SR upper write viol", 32'(vl), 32'd1);
    tick();
    chk("R9", "viol one cycle", 32'(priv_viol), 32'd0);
    chk("R9", "still user", 32'(sup_mode), 32'd0);
    crr(2'd0, v, vl); chk("R9", "SR unchanged", v, 32'h00000011);
    crw(2'd1, 1'b0, 32'hFFFF0000, vl);
    chk("R9", "VBR write viol", 32'(vl), 32'd1);
    vec_num = 8'd1;
    tick();
    chk("R9", "VBR unchanged via vector", vec_addr, 32'h00002004);
    crr(2'd1, v, vl); chk("R9", "VBR read blocked data", v, 32'h0);
    chk("R9", "VBR read viol", 32'(vl), 32'd1);
    crw(2'd2, 1'b0, 32'h00000002, vl);
    chk("R9", "SFC write viol", 32'(vl), 32'd1);
    vec_num = 8'd0;
  endtask

  task automatic t_vector();
    logic [31:0] v; logic vl;
    do_reset();
    crw(2'd1, 1'b0, 32'h00010000, vl);
    vec_num = 8'h40; tick();
    chk("R11", "vec 0x40", vec_addr, 32'h00010100);
    vec_num = 8'hFF; tick();
    chk("R11", "vec 0xFF", vec_addr, 32'h000103FC);
    vec_num = 8'h10;
    cr_en = 1; cr_we = 1; cr_sel = 2'd1; cr_wdata = 32'h00003000;
    tick();
    cr_en = 0; cr_we = 0;
    chk("R11", "same-cycle VBR write uses old", vec_addr, 32'h00010040);
    tick();
    chk("R11", "new VBR next cycle", vec_addr, 32'h00003040);
    vec_num = 8'h0;
    crw(2'd2, 1'b0, 32'hFFFFFFFF, vl);
    crw(2'd3, 1'b0, 32'h0000000D, vl);
    crr(2'd2, v, vl); chk("R12", "SFC 3 bits", v, 32'h7);
    crr(2'd3, v, vl); chk("R12", "DFC 3 bits", v, 32'h5);
  endtask

  initial begin
    t_reset();
    t_data_sizes();
    t_addr();
    t_same_cycle();
    t_bank();
    t_sr_super();
    t_user();
    t_vector();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule